// File: doc/BRIEF.md
# Nibble-Multiplexed Transmit Word Packer

This block sits on the host side of a full-duplex converter link and turns parallel 10-bit transmit samples into a stream of half-words on a 6-bit bus. One sample is consumed every two link-clock cycles. The block drives its upper half first and its lower half second, unless configured otherwise. A frame sync line runs beside the bus and tells the receiver which half of the word is on the pins.

Five static configuration inputs choose the behaviour. They set an uneven 6/4 split or an even 5/5 split, the half sent first, the sync level that marks the first half, two's complement or offset binary output, and launch on the rising or falling link-clock edge. Samples enter through a valid/ready handshake. If no sample is waiting when a word slot opens, an all-zero word is sent instead, so the bus framing never stalls. Configuration is sampled once per word, together with the sample.

The control is a three-state machine. `ST_IDLE` is the reset state. `ST_HEAD` drives the first half-word and `ST_TAIL` drives the second. The transitions are `ST_IDLE -> ST_HEAD` on the first clock edge after reset, `ST_HEAD -> ST_TAIL` on every edge, and `ST_TAIL -> ST_HEAD` on every edge. A word slot is loaded on each edge that enters `ST_HEAD`.

Top module: `nib_tx_packer`

## Requirements
- R1: While reset is asserted the block is in `ST_IDLE`: `tx_data` is 0, `tx_sync` is 1 and `s_ready` is 1. The first rising edge after reset is released loads a word slot.
- R2: `s_ready` is high in `ST_IDLE` and `ST_TAIL` and low in `ST_HEAD`. A sample presented with `s_valid` high is taken on a rising edge where `s_ready` is high, and its first half-word appears in the following cycle.
- R3: With `cfg_split_even`=0, the upper half-word drives word bits [9:4] on bus bits [5:0]. The lower half-word drives word bits [3:0] on bus bits [3:0], with bus bits [5:4] at 0.
- R4: With `cfg_split_even`=1, the upper half drives word bits [9:5] and the lower half drives word bits [4:0], both on bus bits [5:1], with bus bit [0] at 0.
- R5: With `cfg_low_first`=0 the upper half goes out in `ST_HEAD` and the lower half in `ST_TAIL`. With `cfg_low_first`=1 the order is reversed.
- R6: In `ST_HEAD`, `tx_sync` equals `cfg_sync_high_first` and in `ST_TAIL` it is the inverse, so it changes level inside every word.
- R7: With `cfg_to_offset`=1, bit 9 of the sample is inverted before the split. Other bits pass unchanged.
- R8: If `s_valid` is low on the edge that loads a word slot, both half-words of that slot are all zeros on the bus.
- R9: All five configuration inputs are sampled only on the edge that loads a word slot. Changes at any other time do not alter the word already in flight.
- R10: With `cfg_fall_launch`=0, the bus and sync change just after the rising edge. With it set to 1, they hold the previous cycle's values until the falling edge and then take the same values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Sample available |
| s_data | input | 10 | Sample, two's complement |
| s_ready | output | 1 | Block takes a sample on this edge |
| cfg_split_even | input | 1 | 1: 5/5 split on bus [5:1]; 0: 6/4 split |
| cfg_low_first | input | 1 | 1: lower half-word goes out first |
| cfg_sync_high_first | input | 1 | Sync level during the first half-word |
| cfg_to_offset | input | 1 | 1: convert to offset binary |
| cfg_fall_launch | input | 1 | 1: launch outputs on the falling edge |
| tx_data | output | 6 | Half-word bus |
| tx_sync | output | 1 | Frame sync |

## Verification
The bench aims at sample values whose sign bit and half-word boundaries are the ones a wrong split or conversion would expose, such as 0x200, 0x1FF and 0x3FF. It runs these under all 32 configuration combinations, so a design that swapped the padding bits or shifted the even split onto bits [4:0] would show wrong bus values. Configuration inputs are changed in the middle of words. A design that sampled them outside the slot-loading edge would split a word across two settings. Gaps with no valid sample are included, and a design that repeated the last word instead of zeros would be caught there. The bus is also observed shortly after each rising edge, so a falling-edge launch that acted immediately, or not at all, would show up.

// File: rtl/nib_tx_pkg.sv
package nib_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_TAIL = 2'd2
    } pk_state_e;

    typedef struct packed {
        logic split_even;
        logic low_first;
        logic sync_high_first;
        logic to_offset;
        logic fall_launch;
    } pk_cfg_t;

endpackage

// File: rtl/nib_tx_split.sv
module nib_tx_split #(
    parameter int WORD_W = 10,
    parameter int BUS_W  = 6,
    parameter int HI_W   = 6
) (
    input  logic [WORD_W-1:0] word,
    input  logic              split_even,
    input  logic              low_first,
    output logic [BUS_W-1:0]  first_nib,
    output logic [BUS_W-1:0]  second_nib
);
    localparam int LO_W   = WORD_W - HI_W;
    localparam int HALF_W = WORD_W / 2;

    logic [BUS_W-1:0] upper_nib;
    logic [BUS_W-1:0] lower_nib;

    always_comb begin
        upper_nib = '0;
        lower_nib = '0;
        if (split_even) begin
            upper_nib[BUS_W-1 -: HALF_W] = word[WORD_W-1 -: HALF_W];
            lower_nib[BUS_W-1 -: HALF_W] = word[HALF_W-1:0];
        end else begin
            upper_nib[HI_W-1:0] = word[WORD_W-1 -: HI_W];
            lower_nib[LO_W-1:0] = word[LO_W-1:0];
        end
    end

    assign first_nib  = low_first ? lower_nib : upper_nib;
    assign second_nib = low_first ? upper_nib : lower_nib;

endmodule

// File: rtl/nib_tx_launch.sv
module nib_tx_launch #(
    parameter int BUS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_sel,
    input  logic [BUS_W-1:0] rise_data,
    input  logic             rise_sync,
    output logic [BUS_W-1:0] out_data,
    output logic             out_sync
);
    logic [BUS_W-1:0] fall_data_q;
    logic             fall_sync_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_data_q <= '0;
            fall_sync_q <= 1'b1;
        end else begin
            fall_data_q <= rise_data;
            fall_sync_q <= rise_sync;
        end
    end

    assign out_data = fall_sel ? fall_data_q : rise_data;
    assign out_sync = fall_sel ? fall_sync_q : rise_sync;

    // R10: at each rising edge the launched bus carries the value prepared for the ending cycle
    p_launch_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_data == rise_data) && (out_sync == rise_sync));

endmodule

// File: rtl/nib_tx_packer.sv
module nib_tx_packer #(
    parameter int WORD_W = 10,
    parameter int BUS_W  = 6,
    parameter int HI_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [WORD_W-1:0] s_data,
    output logic              s_ready,
    input  logic              cfg_split_even,
    input  logic              cfg_low_first,
    input  logic              cfg_sync_high_first,
    input  logic              cfg_to_offset,
    input  logic              cfg_fall_launch,
    output logic [BUS_W-1:0]  tx_data,
    output logic              tx_sync
);
    import nib_tx_pkg::*;

    localparam logic [WORD_W-1:0] SIGN_MASK = {1'b1, {(WORD_W-1){1'b0}}};

    pk_state_e         state, state_nx;
    pk_cfg_t           cfg_q, cfg_in;
    logic [WORD_W-1:0] word_q;
    logic              load_slot;
    logic [BUS_W-1:0]  first_nib, second_nib;
    logic [BUS_W-1:0]  rise_data;
    logic              rise_sync;

    assign cfg_in = '{split_even:      cfg_split_even,
                      low_first:       cfg_low_first,
                      sync_high_first: cfg_sync_high_first,
                      to_offset:       cfg_to_offset,
                      fall_launch:     cfg_fall_launch};

    assign load_slot = (state != ST_HEAD);
    assign s_ready   = load_slot;

    // next-state logic
    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = ST_HEAD;
            ST_HEAD: state_nx = ST_TAIL;
            ST_TAIL: state_nx = ST_HEAD;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // word slot: sample and settings captured together
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            cfg_q  <= '0;
        end else if (load_slot) begin
            cfg_q  <= cfg_in;
            word_q <= s_valid ? (cfg_to_offset ? (s_data ^ SIGN_MASK) : s_data)
                              : '0;
        end
    end

    nib_tx_split #(
        .WORD_W (WORD_W),
        .BUS_W  (BUS_W),
        .HI_W   (HI_W)
    ) u_split (
        .word       (word_q),
        .split_even (cfg_q.split_even),
        .low_first  (cfg_q.low_first),
        .first_nib  (first_nib),
        .second_nib (second_nib)
    );

    // output decode
    always_comb begin
        unique case (state)
            ST_HEAD: begin
                rise_data = first_nib;
                rise_sync = cfg_q.sync_high_first;
            end
            ST_TAIL: begin
                rise_data = second_nib;
                rise_sync = ~cfg_q.sync_high_first;
            end
            default: begin
                rise_data = '0;
                rise_sync = 1'b1;
            end
        endcase
    end

    nib_tx_launch #(
        .BUS_W (BUS_W)
    ) u_launch (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_sel  (cfg_q.fall_launch),
        .rise_data (rise_data),
        .rise_sync (rise_sync),
        .out_data  (tx_data),
        .out_sync  (tx_sync)
    );

    // R1: idle lasts exactly one cycle after reset
    p_idle_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (state == ST_HEAD));

    // R2: readiness alternates once words are flowing
    p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);
    p_ready_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !s_ready |=> s_ready);

    // R4: even split leaves the lowest pin quiet
    p_pad_bit0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && cfg_q.split_even) |-> (rise_data[0] == 1'b0));

    // R6: sync changes level between the halves of one word
    p_sync_alt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL) |-> (rise_sync != $past(rise_sync)));

    // R8: an empty slot sends zeros
    p_filler_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HEAD && !$past(s_valid)) |-> (rise_data == '0));

    // R9: slot contents frozen for the second half
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL) |-> ($stable(cfg_q) && $stable(word_q)));

endmodule

// File: tb/nib_tx_packer_tb.sv
`timescale 1ns/1ps
module nib_tx_packer_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       s_valid;
    logic [9:0] s_data;
    logic       s_ready;
    logic [4:0] cfg;        // [4] split_even [3] low_first [2] sync_high_first [1] to_offset [0] fall_launch
    logic [5:0] tx_data;
    logic       tx_sync;

    always #2 clk = ~clk;

    nib_tx_packer u_dut (
        .clk                 (clk),
        .rst_n               (rst_n),
        .s_valid             (s_valid),
        .s_data              (s_data),
        .s_ready             (s_ready),
        .cfg_split_even      (cfg[4]),
        .cfg_low_first       (cfg[3]),
        .cfg_sync_high_first (cfg[2]),
        .cfg_to_offset       (cfg[1]),
        .cfg_fall_launch     (cfg[0]),
        .tx_data             (tx_data),
        .tx_sync             (tx_sync)
    );

    int         checks = 0;
    int         fails  = 0;
    bit         done   = 0;
    int         m_phase = 0;   // 0 idle, 1 head, 2 tail
    logic [9:0] m_word  = '0;
    logic [4:0] m_cfg   = '0;
    bit         m_filler = 0;
    logic [5:0] exp_d, prev_d = '0;
    logic       exp_s, prev_s = 1'b1;

    function automatic logic [5:0] bench_nib(logic [9:0] w, bit even, bit lowpart);
        if (even) return lowpart ? {w[4:0], 1'b0} : {w[9:5], 1'b0};
        return lowpart ? {2'b00, w[3:0]} : w[9:4];
    endfunction

    task automatic chk(string tag, string what, logic [5:0] got, logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic step();
        string tag;
        @(posedge clk);
        if (rst_n) begin
            if (m_phase != 1) begin
                m_cfg    = cfg;
                m_filler = !s_valid;
                m_word   = s_valid ? (s_data ^ {cfg[1], 9'b0}) : 10'd0;
                m_phase  = 1;
            end else begin
                m_phase = 2;
            end
        end
        case (m_phase)
            1: begin exp_d = bench_nib(m_word, m_cfg[4], m_cfg[3]);  exp_s = m_cfg[2];  end
            2: begin exp_d = bench_nib(m_word, m_cfg[4], !m_cfg[3]); exp_s = !m_cfg[2]; end
            default: begin exp_d = 6'd0; exp_s = 1'b1; end
        endcase
        #1;
        // R10: shortly after the rising edge, falling launch still shows the prior cycle
        chk("R10", "early data", tx_data, m_cfg[0] ? prev_d : exp_d);
        chk("R10", "early sync", {5'd0, tx_sync}, {5'd0, m_cfg[0] ? prev_s : exp_s});
        #2;
        if (m_phase == 0)                    tag = "R1";
        else if (m_filler)                   tag = "R8";
        else if (m_phase == 2 && cfg != m_cfg) tag = "R9";
        else if (m_cfg[3])                   tag = "R5";
        else if (m_cfg[1])                   tag = "R7";
        else if (m_cfg[4])                   tag = "R4";
        else                                 tag = "R3";
        chk(tag, "data", tx_data, exp_d);
        chk((m_phase == 0) ? "R1" : "R6", "sync", {5'd0, tx_sync}, {5'd0, exp_s});
        chk((m_phase == 0) ? "R1" : "R2", "ready", {5'd0, s_ready}, {5'd0, (m_phase != 1)});
        prev_d = exp_d;
        prev_s = exp_s;
    endtask

    // present a new sample only after the previous one was taken
    task automatic offer(bit v, logic [9:0] d);
        if (m_phase == 1) begin
            s_valid = v;
            s_data  = d;
        end
    endtask

    initial begin
        logic [9:0] corner [5];
        corner[0] = 10'h3A5; corner[1] = 10'h200; corner[2] = 10'h1FF;
        corner[3] = 10'h000; corner[4] = 10'h3FF;
        void'($urandom(32'd4321));
        rst_n = 1'b0; s_valid = 1'b0; s_data = '0; cfg = '0;
        repeat (3) step();                 // R1 reset state
        rst_n = 1'b1;
        s_valid = 1'b1; s_data = corner[0];
        // directed corner words, default mode (R3, R6, R2)
        for (int i = 1; i < 12; i++) begin
            step();
            offer(1'b1, corner[(i / 2) % 5]);
        end
        // every configuration with corner and random words (R3..R7, R10)
        for (int c = 0; c < 32; c++) begin
            cfg = c[4:0];
            for (int k = 0; k < 12; k++) begin
                step();
                offer(1'b1, (k < 10) ? corner[k / 2] : 10'($urandom));
            end
        end
        // empty slots (R8)
        cfg = 5'b00000;
        for (int k = 0; k < 8; k++) begin
            step();
            offer(1'b0, 10'h155);
        end
        cfg = 5'b10110;
        for (int k = 0; k < 8; k++) begin
            step();
            offer(1'b0, 10'h2AA);
        end
        // random traffic with mid-word setting changes (R9)
        for (int k = 0; k < 3000; k++) begin
            step();
            if ($urandom % 8 == 0) cfg = 5'($urandom);
            offer(($urandom % 4) != 0, 10'($urandom));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule